// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer with Second/Minute Prescaler

This block is a 16-bit watchdog down-counter that a host programs through a small byte-wide register port. Each decrement is paced either by an external one-second tick or by one minute built from sixty of those ticks, chosen by a configuration bit. The counter is refilled from a programmed reload value, either when software writes that value or, after a short fixed delay, when a peripheral activity strobe arrives from a source that software has enabled. The sources are infrared-receiver, mouse, keyboard and game-port activity.

When a running count decrements to zero, a sticky timeout flag is raised. If the keyboard-reset enable is set, a reset pulse of fixed length is also issued. Software can also force a timeout at once. A reload value of zero parks the counter, which is how the watchdog is stopped. The tick source and the pin drivers that consume the reset pulse are outside this block.

The register port accepts one access in any cycle that `bus_valid` is high. `bus_ready` is held high, so the port never applies back-pressure and a write takes effect at the clock edge that samples it. Read data is a combinational function of `bus_addr`.

Top module: `wdog_evreload`

## Requirements
- R1: After reset, `tmo_status` and `kbd_rst_pulse` are low, `bus_ready` is high, and all four registers read 0x00.
- R2: The register map is: 0x71 control, 0x72 configuration, 0x73 reload low byte, 0x74 reload high byte.
  - Control bits 7..4 enable reload from infrared, mouse, keyboard and game-port activity. Bit 1 is write-only force and reads 0. Bit 0 is the timeout flag.
  - Configuration bit 7 selects seconds (1) or minutes (0). Bit 6 enables the keyboard-reset pulse. Bits 5 and 4 are stored and read back.
  - `bus_ready` is always high.
- R3: In seconds mode with configuration bit 7 set, a reload value N≥1 reaches zero on the Nth `sec_tick` after the reload, and `tmo_status` rises at that tick's edge.
- R4: In minutes mode with configuration bit 7 clear, the counter decrements once every 60 ticks, so a reload value N times out on tick 60·N.
- R5: A count of zero is held and never wraps. Reloading zero stops the watchdog, and no timeout ever comes from a held zero.
- R6: An activity strobe from an enabled source reloads the counter exactly RELOAD_DLY cycles after the strobe is sampled, not earlier. Strobes from disabled sources have no effect.
- R7: Writing control with bit 1 set raises the timeout at the edge of that write, whatever the count is.
- R8: The timeout flag stays set until a control write with bit 0 clear. A control write with bit 0 set leaves the flag unchanged.
- R9: On a timeout with configuration bit 6 set, `kbd_rst_pulse` goes high for exactly RST_LEN cycles, starting right after the timeout edge. Timeouts that arrive during the pulse are ignored. With bit 6 clear, no pulse is issued.
- R10: If a reload and the final decrement fall on the same edge, the reload wins and no timeout occurs.
- R11: If a timeout and a flag-clearing control write fall on the same edge, the flag is set.
- R12: Writing either reload byte reloads the counter on the next cycle and clears the minute prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access valid |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| evt_ir | input | 1 | Infrared receiver activity strobe |
| evt_mouse | input | 1 | Mouse activity strobe |
| evt_kbd | input | 1 | Keyboard activity strobe |
| evt_game | input | 1 | Game-port activity strobe |
| kbd_rst_pulse | output | 1 | Keyboard reset pulse on timeout |
| tmo_status | output | 1 | Sticky timeout flag |

## Verification
The critical overlap is a delayed keepalive reload landing on the same edge as the tick that would take the count from one to zero. The bench provokes it by timing an activity strobe so that its reload delay ends on a tick edge. It judges the outcome by the flag staying low, and then by the timeout needing the full reload count of further ticks. A second overlap is a clear write on the edge of the final tick; there the flag must end up set. A companion case fires a tick before the delay has run out, which confirms that the reload is not applied early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h71;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 8'h72;
  localparam logic [ADDR_W-1:0] ADDR_VLO  = 8'h73;
  localparam logic [ADDR_W-1:0] ADDR_VHI  = 8'h74;

  localparam int CTRL_STATUS_BIT = 0;
  localparam int CTRL_FORCE_BIT  = 1;
  localparam int CTRL_EN_LSB     = 4;

  typedef struct packed {
    logic unit_sec;
    logic kbd_rst_en;
    logic tmo_out_en;
    logic pwrgood_route;
  } wd_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int NSRC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              expire,
  output logic [NSRC-1:0]   evt_en,
  output logic              unit_sec,
  output logic              kbd_en,
  output logic [VAL_W-1:0]  reload_val,
  output logic              val_wr,
  output logic              force_p,
  output logic              status
);
  localparam int HI_W = VAL_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic [NSRC-1:0] en_q;
  wd_cfg_t         cfg_q;
  logic            status_q;
  logic            val_wr_q;

  logic wr, wr_ctrl, wr_cfg, wr_lo, wr_hi;

  assign wr      = bus_valid && bus_write;
  assign wr_ctrl = wr && (bus_addr == ADDR_CTRL);
  assign wr_cfg  = wr && (bus_addr == ADDR_CFG);
  assign wr_lo   = wr && (bus_addr == ADDR_VLO);
  assign wr_hi   = wr && (bus_addr == ADDR_VHI);
  assign force_p = wr_ctrl && bus_wdata[CTRL_FORCE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      en_q     <= '0;
      cfg_q    <= '0;
      status_q <= 1'b0;
      val_wr_q <= 1'b0;
    end else begin
      val_wr_q <= wr_lo || wr_hi;
      if (wr_ctrl) en_q  <= bus_wdata[CTRL_EN_LSB +: NSRC];
      if (wr_cfg)  cfg_q <= wd_cfg_t'(bus_wdata[7:4]);
      if (wr_lo)   lo_q  <= bus_wdata;
      if (wr_hi)   hi_q  <= bus_wdata[HI_W-1:0];
      // a timeout on the same edge as a clearing write wins
      if (expire)
        status_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CTRL_STATUS_BIT])
        status_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CTRL_EN_LSB +: NSRC] = en_q;
        bus_rdata[CTRL_STATUS_BIT]     = status_q;
      end
      ADDR_CFG: bus_rdata[7:4] = cfg_q;
      ADDR_VLO: bus_rdata      = lo_q;
      ADDR_VHI: bus_rdata      = 8'(hi_q);
      default:  bus_rdata      = '0;
    endcase
  end

  assign evt_en     = en_q;
  assign unit_sec   = cfg_q.unit_sec;
  assign kbd_en     = cfg_q.kbd_rst_en;
  assign reload_val = {hi_q, lo_q};
  assign val_wr     = val_wr_q;
  assign status     = status_q;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int MIN_DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic minute_mode,
  input  logic clr,
  output logic dec_stb
);
  localparam int PW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(MIN_DIV - 1);

  logic [PW-1:0] pre_q;

  assign dec_stb = minute_mode ? (tick && (pre_q == LAST)) : tick;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !minute_mode)
      pre_q <= '0;
    else if (tick)
      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_evreload.sv
module wdog_evsync #(
  parameter int NSRC       = 4,
  parameter int RELOAD_DLY = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en,
  output logic            fire
);
  localparam int DW = $clog2(RELOAD_DLY + 1);
  localparam logic [DW-1:0] LAST = DW'(RELOAD_DLY - 1);

  logic [NSRC-1:0] gated;
  logic            hit;
  logic            pend_q;
  logic [DW-1:0]   dcnt_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = evt[i] & en[i];
  end

  assign hit  = |gated;
  assign fire = pend_q && (dcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else if (fire) begin
      pend_q <= hit;
      dcnt_q <= '0;
    end else if (pend_q) begin
      dcnt_q <= dcnt_q + 1'b1;
    end else if (hit) begin
      pend_q <= 1'b1;
      dcnt_q <= '0;
    end
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec && (cnt != '0))
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdog_rstpulse.sv
module wdog_rstpulse #(
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic en,
  output logic pulse
);
  localparam int LW = $clog2(RST_LEN + 1);

  logic [LW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (trig && en) begin
        act_q <= 1'b1;
        cnt_q <= LW'(RST_LEN - 1);
      end
    end else if (cnt_q == '0) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse = act_q;
endmodule

// File: rtl/wdog_evreload_top.sv
module wdog_evreload
  import wdog_pkg::*;
#(
  parameter int VAL_W      = 16,
  parameter int MIN_DIV    = 60,
  parameter int RELOAD_DLY = 4,
  parameter int RST_LEN    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  output logic       bus_ready,
  input  logic       bus_write,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sec_tick,
  input  logic       evt_ir,
  input  logic       evt_mouse,
  input  logic       evt_kbd,
  input  logic       evt_game,
  output logic       kbd_rst_pulse,
  output logic       tmo_status
);
  localparam int NSRC = 4;

  logic [NSRC-1:0]  evt_vec;
  logic [NSRC-1:0]  evt_en;
  logic             unit_sec;
  logic             kbd_en_w;
  logic [VAL_W-1:0] reload_val;
  logic             val_wr;
  logic             force_p;
  logic             evt_fire;
  logic             dec_stb;
  logic             cnt_load;
  logic [VAL_W-1:0] cnt_q;
  logic             cnt_expire;
  logic             expire_any;

  assign bus_ready = 1'b1;
  // bit order matches control bits 7..4
  assign evt_vec   = {evt_ir, evt_mouse, evt_kbd, evt_game};

  wdog_regs #(.VAL_W(VAL_W), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire(expire_any), .evt_en(evt_en), .unit_sec(unit_sec),
    .kbd_en(kbd_en_w), .reload_val(reload_val), .val_wr(val_wr),
    .force_p(force_p), .status(tmo_status)
  );

  wdog_evsync #(.NSRC(NSRC), .RELOAD_DLY(RELOAD_DLY)) u_evsync (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .en(evt_en), .fire(evt_fire)
  );

  assign cnt_load = val_wr | evt_fire;

  wdog_prescale #(.MIN_DIV(MIN_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .minute_mode(!unit_sec),
    .clr(cnt_load), .dec_stb(dec_stb)
  );

  wdog_downcnt #(.W(VAL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(reload_val),
    .dec(dec_stb), .cnt(cnt_q)
  );

  // a reload on the same edge suppresses the final decrement
  assign cnt_expire = !cnt_load && dec_stb && (cnt_q == VAL_W'(1));
  assign expire_any = cnt_expire | force_p;

  wdog_rstpulse #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(expire_any), .en(kbd_en_w),
    .pulse(kbd_rst_pulse)
  );
endmodule

// File: rtl/wdog_evreload_chk.sv
module wdog_evreload_chk
  import wdog_pkg::*;
#(
  parameter int VAL_W   = 16,
  parameter int RST_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ready,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             tmo_status,
  input logic             kbd_rst_pulse,
  input logic             kbd_en,
  input logic [VAL_W-1:0] cnt,
  input logic             cnt_load,
  input logic             expire
);
  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             run_q <= '0;
    else if (kbd_rst_pulse) run_q <= run_q + 1'b1;
    else                    run_q <= '0;
  end

  assert_always_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_status) |-> $past(bus_valid && bus_write &&
                                bus_addr == ADDR_CTRL && !bus_wdata[CTRL_STATUS_BIT]));

  assert_expire_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo_status);

  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !cnt_load) |=> (cnt == '0));

  assert_pulse_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_rst_pulse) |-> $past(expire && kbd_en));

  assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 16'(RST_LEN));
endmodule

bind wdog_evreload wdog_evreload_chk #(.VAL_W(VAL_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .tmo_status(tmo_status), .kbd_rst_pulse(kbd_rst_pulse), .kbd_en(kbd_en_w),
  .cnt(cnt_q), .cnt_load(cnt_load), .expire(expire_any)
);

// File: tb/wdog_evreload_tb.sv
module wdog_evreload_tb;
  localparam int MIN_DIV    = 60;
  localparam int RELOAD_DLY = 4;
  localparam int RST_LEN    = 8;
  localparam logic [7:0] A_CTRL = 8'h71, A_CFG = 8'h72, A_LO = 8'h73, A_HI = 8'h74;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_ready;
  logic [7:0] bus_rdata;
  logic sec_tick = 1'b0;
  logic evt_ir = 1'b0, evt_mouse = 1'b0, evt_kbd = 1'b0, evt_game = 1'b0;
  logic kbd_rst_pulse, tmo_status;

  int vectors = 0;
  int errs = 0;
  int pulse_total = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (kbd_rst_pulse) pulse_total++;

  wdog_evreload #(.MIN_DIV(MIN_DIV), .RELOAD_DLY(RELOAD_DLY), .RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sec_tick(sec_tick), .evt_ir(evt_ir),
    .evt_mouse(evt_mouse), .evt_kbd(evt_kbd), .evt_game(evt_game),
    .kbd_rst_pulse(kbd_rst_pulse), .tmo_status(tmo_status)
  );

  function automatic int exp_ticks(input bit minute, input int v);
    return minute ? v * MIN_DIV : v;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      sec_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ir();
    evt_ir = 1'b1;
    @(posedge clk); @(negedge clk);
    evt_ir = 1'b0;
  endtask

  task automatic load_val(input int v);
    wr(A_HI, 8'(v >> 8));
    wr(A_LO, 8'(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run incomplete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int snap;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", tmo_status, 0);
    check("R1 pulse", kbd_rst_pulse, 0);
    check("R1 ready", bus_ready, 1);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_CFG, d);  check("R1 cfg", d, 0);
    rd(A_LO, d);   check("R1 lo", d, 0);
    rd(A_HI, d);   check("R1 hi", d, 0);

    // R2 readback
    wr(A_CFG, 8'hF0); rd(A_CFG, d); check("R2 cfg", d, 8'hF0);
    wr(A_CTRL, 8'hF0); rd(A_CTRL, d); check("R2 ctrl", d, 8'hF0);
    wr(A_HI, 8'hAB); wr(A_LO, 8'hCD);
    rd(A_HI, d); check("R2 hi", d, 8'hAB);
    rd(A_LO, d); check("R2 lo", d, 8'hCD);

    // R3 seconds mode, 16-bit value
    wr(A_CFG, 8'h80); wr(A_CTRL, 8'h00); load_val(16'h0102);
    tick(257); check("R3 before", tmo_status, 0);
    tick(1);   check("R3 at zero", tmo_status, 1);

    // R5 hold at zero, no further timeout
    wr(A_CTRL, 8'h00); tick(20); check("R5 held zero", tmo_status, 0);
    load_val(0); tick(40); check("R5 stopped", tmo_status, 0);

    // R8 write with bit0 set leaves flag
    load_val(1); tick(1); check("R8 set", tmo_status, 1);
    wr(A_CTRL, 8'h01); check("R8 bit0 set keeps", tmo_status, 1);
    wr(A_CTRL, 8'h00); check("R8 cleared", tmo_status, 0);

    // R4 minutes mode
    wr(A_CFG, 8'h00); load_val(2);
    tick(119); check("R4 before", tmo_status, 0);
    tick(1);   check("R4 at zero", tmo_status, 1);

    // R12 value write clears prescaler
    wr(A_CTRL, 8'h00); load_val(1); tick(30);
    wr(A_LO, 8'h01);
    tick(59); check("R12 before", tmo_status, 0);
    tick(1);  check("R12 at zero", tmo_status, 1);

    // R7 force and R9 pulse enabled
    wr(A_CFG, 8'hC0); wr(A_CTRL, 8'h00); load_val(0);
    snap = pulse_total;
    wr(A_CTRL, 8'h02); check("R7 force", tmo_status, 1);
    rd(A_CTRL, d); check("R7 force reads 0", d, 8'h01);
    idle(RST_LEN + 4); check("R9 pulse length", pulse_total - snap, RST_LEN);

    // R9 no pulse when disabled
    wr(A_CFG, 8'h80); wr(A_CTRL, 8'h00);
    snap = pulse_total;
    wr(A_CTRL, 8'h02); idle(RST_LEN + 4);
    check("R9 disabled", pulse_total - snap, 0);

    // R6 disabled source ignored
    wr(A_CTRL, 8'h80); load_val(2); tick(1);
    evt_mouse = 1'b1; @(posedge clk); @(negedge clk); evt_mouse = 1'b0;
    idle(8); tick(1); check("R6 disabled source", tmo_status, 1);

    // R6 reload not early, then applied
    wr(A_CTRL, 8'h80); load_val(1);
    pulse_ir(); idle(1); tick(1);
    check("R6 early tick expires", tmo_status, 1);
    idle(4); wr(A_CTRL, 8'h80); tick(1);
    check("R6 reload applied", tmo_status, 1);

    // R10 reload meets final decrement
    wr(A_CTRL, 8'h80); load_val(3); tick(2);
    pulse_ir(); idle(RELOAD_DLY - 1); tick(1);
    check("R10 reload wins", tmo_status, 0);
    tick(2); check("R10 full count left", tmo_status, 0);
    tick(1); check("R10 expire", tmo_status, 1);

    // R11 clearing write on the expiry edge
    wr(A_CTRL, 8'h00); load_val(1);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_CTRL; bus_wdata = 8'h00;
    sec_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; sec_tick = 1'b0;
    check("R11 set wins", tmo_status, 1);

    // random mix of R3 and R4 with R9
    for (int i = 0; i < 8; i++) begin
      bit minute, kb;
      int v, n;
      minute = 1'($urandom % 2);
      kb     = 1'($urandom % 2);
      v      = minute ? 1 + int'($urandom % 2) : 1 + int'($urandom % 40);
      n      = exp_ticks(minute, v);
      wr(A_CFG, (minute ? 8'h00 : 8'h80) | (kb ? 8'h40 : 8'h00));
      wr(A_CTRL, 8'h00);
      load_val(v);
      tick(n - 1);
      check(minute ? "R4 rnd before" : "R3 rnd before", tmo_status, 0);
      snap = pulse_total;
      tick(1);
      check(minute ? "R4 rnd expire" : "R3 rnd expire", tmo_status, 1);
      idle(RST_LEN + 2);
      check("R9 rnd pulse", pulse_total - snap, kb ? RST_LEN : 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule